// File: doc/BRIEF.md
# Conversion Power and Reference Sequencer

This controller decides when the converter core and the on-chip reference draw power. The serial interface is never gated: it stays live in every power state. When the interface reports that its own address has matched, the core is switched on, and it is switched off again as soon as the conversion reports completion. Between conversions the core therefore sits idle at minimum power without any request from the host.

The reference follows its own rules. It wakes at the ninth falling clock edge of a byte whose address matched. On that same edge the read/write flag of the address is sampled. A zero arms a reference shutdown, which is carried out only when the host later declines a result byte with a NACK. A one keeps the reference on and cancels any shutdown still armed. After every wake-up a programmable settle counter, running on the system clock, holds the reference-valid flag low until it expires. The host uses that flag to discard the dummy conversion that wakes the reference. In external-reference mode the internal reference stays off, the flag is ignored, and the reference is reported valid.

All inputs are single-cycle strobes or levels in the system clock domain. No data stream passes through the block, so it has no valid/ready handshake and nothing ever stalls.

Top module: `refpwr_seq`

## Requirements
- R1: Out of reset with `ext_ref_mode` low, `core_en`, `ref_en` and `ref_ready` are all 0.
- R2: An `addr_match` pulse sets `core_en` to 1 on the next clock.
- R3: A `conv_done` pulse sets `core_en` to 0 on the next clock. If `addr_match` arrives in the same cycle, `addr_match` wins and `core_en` stays 1.
- R4: An `addr_edge9` pulse counts only when an `addr_match` came earlier and has not yet been consumed, or when both arrive in the same cycle. In internal mode a counted pulse sets `ref_en` to 1 on the next clock. An uncounted `addr_edge9` changes nothing.
- R5: A counted `addr_edge9` with `rw_flag`=1 keeps the reference on. A later `master_nack` then leaves `ref_en` at 1.
- R6: A counted `addr_edge9` with `rw_flag`=0 arms a shutdown. The next `master_nack` sets `ref_en` to 0 on the following clock and clears the arm.
- R7: A counted `addr_edge9` with `rw_flag`=1, arriving while a shutdown is armed, cancels the armed shutdown.
- R8: While `ext_ref_mode` is 1, `ref_en` is 0 from the next clock on, `rw_flag` has no effect, and `ref_ready` is 1.
- R9: In internal mode, `ref_ready` rises exactly `SETTLE_CYCLES` clocks after the clock on which `ref_en` rose. It falls in the same cycle as `ref_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_match | input | 1 | Strobe: own address recognised |
| addr_edge9 | input | 1 | Strobe: ninth falling clock edge of an address byte |
| rw_flag | input | 1 | Read/write bit of the address, sampled on a counted `addr_edge9` |
| conv_done | input | 1 | Strobe: conversion complete |
| master_nack | input | 1 | Strobe: host declined a result byte |
| ext_ref_mode | input | 1 | Level: 1 selects an external reference |
| core_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Internal reference power enable |
| ref_ready | output | 1 | Reference settled and results are valid |

## Verification
A table drives one long sequence in internal mode. It contains `addr_edge9` pulses both with and without a preceding match, which separates real wake-ups from foreign traffic. It places NACKs with a shutdown armed, with no shutdown armed, and after a shutdown was cancelled, which separates R5, R6 and R7. It also drives match and done together, which exposes the priority of R3. The external-mode rows repeat the same strobes to show that `rw_flag` and the wake-up are ignored there. Directed tests count the exact number of clocks from `ref_en` rising to `ref_ready` rising, and check that `ref_ready` drops together with `ref_en`.

// File: rtl/refpwr_pkg.sv
package refpwr_pkg;
  typedef enum logic {
    CORE_SLEEP = 1'b0,
    CORE_AWAKE = 1'b1
  } core_state_e;

  // width of a counter that must hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/core_pwr_ctl.sv
module core_pwr_ctl
  import refpwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic core_en_o
);
  core_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= CORE_SLEEP;
    else if (start_i) state_q <= CORE_AWAKE;   // new conversion wins
    else if (done_i)  state_q <= CORE_SLEEP;
  end

  assign core_en_o = (state_q == CORE_AWAKE);
endmodule

// File: rtl/ref_gate_ctl.sv
module ref_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic edge9_i,
  input  logic rw_i,
  input  logic nack_i,
  input  logic ext_i,
  output logic ref_en_o
);
  logic pend_q;
  logic armed_q;
  logic ref_q;
  logic hit;

  // ninth edge counts only for a byte that carried our own address
  assign hit = edge9_i & (pend_q | match_i);

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (hit)     pend_q <= 1'b0;
    else if (match_i) pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (ext_i) begin
      ref_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (hit) begin
      ref_q   <= 1'b1;
      armed_q <= ~rw_i;
    end else if (nack_i && armed_q) begin
      ref_q   <= 1'b0;
      armed_q <= 1'b0;
    end
  end

  assign ref_en_o = ref_q;
endmodule

// File: rtl/ref_settle_timer.sv
module ref_settle_timer
  import refpwr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 2_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic settled_o
);
  localparam int CW = cnt_width(SETTLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign settled_o = done_q;
endmodule

// File: rtl/refpwr_seq.sv
module refpwr_seq #(
  parameter int SETTLE_CYCLES = 2_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_match,
  input  logic addr_edge9,
  input  logic rw_flag,
  input  logic conv_done,
  input  logic master_nack,
  input  logic ext_ref_mode,
  output logic core_en,
  output logic ref_en,
  output logic ref_ready
);
  logic settled;

  core_pwr_ctl u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (addr_match),
    .done_i   (conv_done),
    .core_en_o(core_en)
  );

  ref_gate_ctl u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .match_i (addr_match),
    .edge9_i (addr_edge9),
    .rw_i    (rw_flag),
    .nack_i  (master_nack),
    .ext_i   (ext_ref_mode),
    .ref_en_o(ref_en)
  );

  ref_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (ref_en),
    .settled_o(settled)
  );

  assign ref_ready = ext_ref_mode | (ref_en & settled);
endmodule

// File: rtl/refpwr_seq_chk.sv
module refpwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_match,
  input logic addr_edge9,
  input logic conv_done,
  input logic master_nack,
  input logic ext_ref_mode,
  input logic core_en,
  input logic ref_en,
  input logic ref_ready
);
  assert_match_wakes_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> core_en);

  assert_done_sleeps_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !addr_match) |=> !core_en);

  assert_ext_keeps_ref_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ref_mode |=> !ref_en);

  assert_wake_needs_edge9_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> $past(addr_edge9));

  assert_off_needs_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_en) |-> $past(master_nack || ext_ref_mode));

  assert_ready_after_settle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_ready) && !ext_ref_mode) |-> $past(ref_en));
endmodule

bind refpwr_seq refpwr_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_match  (addr_match),
  .addr_edge9  (addr_edge9),
  .conv_done   (conv_done),
  .master_nack (master_nack),
  .ext_ref_mode(ext_ref_mode),
  .core_en     (core_en),
  .ref_en      (ref_en),
  .ref_ready   (ref_ready)
);

// File: tb/tb_refpwr_seq.sv
`timescale 1ns/1ps
module tb_refpwr_seq;
  localparam int SETTLE = 20;
  localparam int NSTEP  = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_match = 0, addr_edge9 = 0, rw_flag = 0, conv_done = 0;
  logic master_nack = 0, ext_ref_mode = 0;
  logic core_en, ref_en, ref_ready;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  refpwr_seq #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .addr_match(addr_match), .addr_edge9(addr_edge9),
    .rw_flag(rw_flag), .conv_done(conv_done), .master_nack(master_nack),
    .ext_ref_mode(ext_ref_mode), .core_en(core_en), .ref_en(ref_en),
    .ref_ready(ref_ready)
  );

  // {match, edge9, rw, done, nack, ext, exp_core, exp_ref}
  localparam logic [7:0] STEPS [NSTEP] = '{
    8'b000000_00, // 0 idle
    8'b011000_00, // 1 edge9 with no match: ignored
    8'b100000_10, // 2 match: core on
    8'b010000_11, // 3 edge9 rw=0: ref on, armed
    8'b000100_01, // 4 done: core off
    8'b100000_11, // 5 match
    8'b011000_11, // 6 edge9 rw=1: cancels arm
    8'b000100_01, // 7 done
    8'b000010_01, // 8 nack: arm was cancelled
    8'b100000_11, // 9 match
    8'b010000_11, // 10 edge9 rw=0: arm
    8'b000100_01, // 11 done
    8'b000010_00, // 12 nack: shutdown
    8'b000010_00, // 13 nack again
    8'b100100_10, // 14 match with done: match wins
    8'b011000_11, // 15 edge9 rw=1
    8'b000010_11, // 16 nack, nothing armed
    8'b000100_01, // 17 done
    8'b000001_00, // 18 ext: ref forced off
    8'b100001_10, // 19 ext match
    8'b011001_10, // 20 ext edge9 rw=1: ignored
    8'b000101_00, // 21 ext done
    8'b000000_00  // 22 back to internal
  };

  function automatic string tag_of(input int i);
    case (i)
      1:                  return "R4";
      2, 5, 9, 19:        return "R2";
      3, 10:              return "R6";
      4, 7, 11, 17, 21:   return "R3";
      6, 8:               return "R7";
      12, 13:             return "R6";
      14:                 return "R3";
      15, 16:             return "R5";
      18, 20:             return "R8";
      default:            return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    addr_match = 0; addr_edge9 = 0; rw_flag = 0;
    conv_done = 0; master_nack = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clear_in();
  endtask

  task automatic do_reset();
    clear_in(); ext_ref_mode = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    // R1 reset state
    check("R1", "core_en after reset", core_en, 0);
    check("R1", "ref_en after reset", ref_en, 0);
    check("R1", "ref_ready after reset", ref_ready, 0);

    // table walk
    for (int i = 0; i < NSTEP; i++) begin
      {addr_match, addr_edge9, rw_flag, conv_done, master_nack, ext_ref_mode} = STEPS[i][7:2];
      step();
      check(tag_of(i), $sformatf("step %0d core_en", i), core_en, STEPS[i][1]);
      check(tag_of(i), $sformatf("step %0d ref_en", i), ref_en, STEPS[i][0]);
    end

    // R9 settle count after wake-up
    do_reset();
    addr_match = 1; step();
    addr_edge9 = 1; rw_flag = 0; step();
    check("R9", "ref_en at wake", ref_en, 1);
    check("R9", "ref_ready at wake", ref_ready, 0);
    n = 0;
    while (!ref_ready && n < 100) begin
      step();
      n++;
    end
    check("R9", "clocks to ref_ready", n, SETTLE);
    // R6 / R9 armed shutdown drops ready together with ref_en
    master_nack = 1; step();
    check("R6", "ref_en after armed nack", ref_en, 0);
    check("R9", "ref_ready after shutdown", ref_ready, 0);

    // R4 match and edge9 in one cycle count
    addr_match = 1; addr_edge9 = 1; rw_flag = 1; step();
    check("R4", "ref_en same-cycle match", ref_en, 1);
    check("R9", "ready low while settling", ref_ready, 0);

    // R8 external mode reports ready and ignores rw
    ext_ref_mode = 1; step();
    check("R8", "ref_en in ext mode", ref_en, 0);
    check("R8", "ref_ready in ext mode", ref_ready, 1);
    addr_match = 1; step();
    addr_edge9 = 1; rw_flag = 0; step();
    check("R8", "ref_en after ext edge9", ref_en, 0);
    ext_ref_mode = 0; step();
    check("R8", "ready leaving ext mode", ref_ready, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule